// File: doc/BRIEF.md
# Compare Timer with Register Bus

This block is a general-purpose up-counting timer. Software reaches it through a small register bus with an address, a write strobe, write data and combinational read data. A free-running counter advances on ticks from one of two strobe inputs. The strobes are a bus-clock tick and a peripheral-clock tick, and both are synchronous enables in the block's clock domain. A programmable prescaler divides the selected tick before it reaches the counter.

One compare register raises a sticky match flag. The flag is set on the tick where the counter steps onto the compare value. Software clears it by writing a one to it. An interrupt-enable bit gates the flag onto a registered level interrupt.

To schedule an event, software reads the counter, adds a delta and writes the sum to the compare register. Because of this, a match is found correctly after the counter wraps. A mode bit picks between two behaviours. In free-run mode the counter counts through a match. In restart mode the counter steps back to zero after a match.

Top module: `cmp_timer`

## Requirements
- R1: While control bit 0 (enable) is 0, neither the counter nor the prescaler divider advances, whatever the tick inputs do.
- R2: Control bits 7:6 select the tick source. Value 1 selects `tick_bus` and value 2 selects `tick_per`. Values 0 and 3 select no source, so the counter does not move.
- R3: The prescaler register is at offset 0x04. A value P gives one counter step per P+1 selected ticks, and P=0 steps on every tick. Any write to this register sets the divider phase back to zero.
- R4: When control bit 9 is 1 (free-run), the counter adds one per step through a compare match and wraps from all-ones to zero.
- R5: When control bit 9 is 0 (restart), the step that follows a step onto the compare value loads zero into the counter.
- R6: Status bit 0 at offset 0x08 is set on a step whose new counter value equals the compare register at offset 0x10. A compare value the counter has already passed matches only after the counter wraps around to it.
- R7: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. When a clear write and a match fall in the same cycle, the flag ends up set.
- R8: `irq` is registered and equals status bit 0 AND bit 0 of the interrupt-enable register at offset 0x0C, taken one cycle earlier. Masking drops `irq` but leaves the flag pending.
- R9: The control register at offset 0x00 stores bits 0, 3, 7:6 and 9, and its other bits read as zero. A write of 0xFFFFFFFF therefore reads back as 0x000002C9.
- R10: The counter is read at offset 0x24, and writes to that offset change nothing. Reads of unmapped offsets return zero.
- R11: After reset every register reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write strobe, one write per cycle while high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tick_bus | input | 1 | Bus-clock tick enable |
| tick_per | input | 1 | Peripheral-clock tick enable |
| irq | output | 1 | Level interrupt |

## Verification
The counting path is driven with bursts on the bus tick followed by bursts on the peripheral tick. Each run uses one source-select code and one prescale value. This separates a wrong source mux, a divider that is off by one, and codes that should select nothing but do. The compare path is tried in four cases:
- a compare value just ahead of the counter;
- a compare value already passed, which must wait for a wrap;
- a value computed as count plus delta that crosses zero;
- restart mode.

These cases separate equality on the new count from equality on the old one, and they show whether the counter restarts or runs on. A clear write placed in the same cycle as a match checks the set-over-clear priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PRE  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_IE   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CMP  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h24;

    localparam int B_EN   = 0;
    localparam int B_WAIT = 3;
    localparam int B_SEL  = 6;
    localparam int B_FREE = 9;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_BUS  = 2'd1,
        SRC_PER  = 2'd2,
        SRC_RSV  = 2'd3
    } src_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [PRE_W-1:0] limit,
    output logic             step
);
    logic [PRE_W-1:0] div_d, div_q;
    logic             hit;

    always_comb begin
        hit   = (div_q == limit);
        step  = run && hit;
        div_d = div_q;
        if (clr)
            div_d = '0;
        else if (run)
            div_d = hit ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |=> (div_q <= $past(limit))) else $error("divider overran limit"); // R3
    AST_DIV_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (div_q == '0)) else $error("divider not cleared"); // R3
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             freerun,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step)
            cnt_d = (!freerun && (cnt_q == cmp)) ? '0 : cnt_q + 1'b1;
        match = step && (cnt_d == cmp);
        cnt   = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q)) else $error("counter moved without step"); // R1
    AST_FREE_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && freerun) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))) else $error("free-run step wrong"); // R4
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !freerun && (cnt_q == cmp)) |=> (cnt_q == '0)) else $error("restart missed"); // R5
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick_bus,
    input  logic              tick_per,
    output logic              irq
);
    typedef struct packed {
        logic             en;
        logic             wt;
        logic [1:0]       sel;
        logic             free;
        logic [PRE_W-1:0] pre;
        logic             ie;
        logic [CNT_W-1:0] cmp;
        logic             flag;
        logic             irq;
    } state_t;

    state_t           st_d, st_q;
    logic             src_tick, run, pre_clr, step, match;
    logic [CNT_W-1:0] cnt;
    logic             wr_ctrl, wr_pre, wr_stat, wr_ie, wr_cmp;

    always_comb begin
        unique case (src_sel_e'(st_q.sel))
            SRC_BUS: src_tick = tick_bus;
            SRC_PER: src_tick = tick_per;
            default: src_tick = 1'b0;
        endcase
        run     = st_q.en && src_tick;
        wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
        wr_pre  = reg_we && (reg_addr == OFS_PRE);
        wr_stat = reg_we && (reg_addr == OFS_STAT);
        wr_ie   = reg_we && (reg_addr == OFS_IE);
        wr_cmp  = reg_we && (reg_addr == OFS_CMP);
        pre_clr = wr_pre;
    end

    tmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (pre_clr),
        .limit (st_q.pre),
        .step  (step)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .freerun (st_q.free),
        .cmp     (st_q.cmp),
        .cnt     (cnt),
        .match   (match)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.en   = reg_wdata[B_EN];
            st_d.wt   = reg_wdata[B_WAIT];
            st_d.sel  = reg_wdata[B_SEL +: 2];
            st_d.free = reg_wdata[B_FREE];
        end
        if (wr_pre) st_d.pre = reg_wdata[PRE_W-1:0];
        if (wr_ie)  st_d.ie  = reg_wdata[0];
        if (wr_cmp) st_d.cmp = reg_wdata[CNT_W-1:0];
        if (match)
            st_d.flag = 1'b1;
        else if (wr_stat && reg_wdata[0])
            st_d.flag = 1'b0;
        st_d.irq = st_q.flag && st_q.ie;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[B_EN]       = st_q.en;
                reg_rdata[B_WAIT]     = st_q.wt;
                reg_rdata[B_SEL +: 2] = st_q.sel;
                reg_rdata[B_FREE]     = st_q.free;
            end
            OFS_PRE:  reg_rdata[PRE_W-1:0] = st_q.pre;
            OFS_STAT: reg_rdata[0] = st_q.flag;
            OFS_IE:   reg_rdata[0] = st_q.ie;
            OFS_CMP:  reg_rdata[CNT_W-1:0] = st_q.cmp;
            OFS_CNT:  reg_rdata[CNT_W-1:0] = cnt;
            default:  reg_rdata = '0;
        endcase
        irq = st_q.irq;
    end

    AST_STEP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> st_q.en) else $error("step while disabled"); // R1
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> st_q.flag) else $error("match lost"); // R7
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[0] && !match) |=> !st_q.flag) else $error("clear ignored"); // R7
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(st_q.ie)) else $error("irq rose while masked"); // R8
    AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(st_q.flag)) else $error("irq without flag"); // R8
endmodule

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, rdata1;
    logic        tick_bus = 1'b0, tick_per = 1'b0;
    logic        irq, irq1;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    cmp_timer u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_bus(tick_bus),
        .tick_per(tick_per), .irq(irq));

    cmp_timer #(.CNT_W(8)) u1 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(rdata1), .tick_bus(tick_bus),
        .tick_per(tick_per), .irq(irq1));

    // sel, prescale, bus ticks, per ticks, expected count
    typedef struct packed {
        logic [1:0]  sel;
        logic [11:0] pre;
        logic [15:0] nb;
        logic [15:0] np;
        logic [31:0] exp;
    } vec_t;
    localparam vec_t VECS [7] = '{
        '{2'd1, 12'd0, 16'd10, 16'd5,  32'd10},
        '{2'd2, 12'd0, 16'd10, 16'd7,  32'd7},
        '{2'd1, 12'd3, 16'd20, 16'd0,  32'd5},
        '{2'd2, 12'd2, 16'd3,  16'd10, 32'd3},
        '{2'd0, 12'd0, 16'd8,  16'd8,  32'd0},
        '{2'd3, 12'd0, 16'd8,  16'd8,  32'd0},
        '{2'd1, 12'd4, 16'd14, 16'd0,  32'd2}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_we = 1'b0; tick_bus = 1'b0; tick_per = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d0, output logic [31:0] d1);
        reg_addr = a;
        #1;
        d0 = reg_rdata;
        d1 = rdata1;
    endtask

    task automatic ticks(logic b, logic p, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_bus = b; tick_per = p;
        end
        @(negedge clk);
        tick_bus = 1'b0; tick_per = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v1;
        // R11: reset state
        do_reset();
        foreach (VECS[i]) begin end
        rd(8'h00, v, v1); chk("R11 ctrl", v, 0);
        rd(8'h04, v, v1); chk("R11 pre", v, 0);
        rd(8'h08, v, v1); chk("R11 stat", v, 0);
        rd(8'h0C, v, v1); chk("R11 ie", v, 0);
        rd(8'h10, v, v1); chk("R11 cmp", v, 0);
        rd(8'h24, v, v1); chk("R11 cnt", v, 0);
        chk("R11 irq", {31'd0, irq}, 0);

        // R2 R3 vector walk
        for (int k = 0; k < 7; k++) begin
            do_reset();
            wr(8'h04, {20'd0, VECS[k].pre});
            wr(8'h00, 32'h201 | ({30'd0, VECS[k].sel} << 6));
            ticks(1'b1, 1'b0, int'(VECS[k].nb));
            ticks(1'b0, 1'b1, int'(VECS[k].np));
            rd(8'h24, v, v1);
            chk($sformatf("R2/R3 vector %0d count", k), v, VECS[k].exp);
        end

        // R9: control mask
        do_reset();
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v, v1); chk("R9 ctrl mask", v, 32'h2C9);

        // R6 R8 R4: match in free-run
        do_reset();
        wr(8'h10, 32'd5);
        wr(8'h0C, 32'd1);
        wr(8'h00, 32'h241);
        ticks(1'b1, 1'b0, 4);
        rd(8'h08, v, v1); chk("R6 no flag before match", v, 0);
        ticks(1'b1, 1'b0, 1);
        rd(8'h08, v, v1); chk("R6 flag on match", v, 1);
        chk("R8 irq lags flag", {31'd0, irq}, 0);
        @(negedge clk);
        chk("R8 irq asserted", {31'd0, irq}, 1);
        ticks(1'b1, 1'b0, 3);
        rd(8'h24, v, v1); chk("R4 counts through match", v, 8);

        // R8: mask keeps flag pending
        wr(8'h0C, 32'd0);
        @(negedge clk);
        chk("R8 masked irq", {31'd0, irq}, 0);
        rd(8'h08, v, v1); chk("R8 flag pending", v, 1);
        wr(8'h0C, 32'd1);
        @(negedge clk);
        chk("R8 unmasked irq", {31'd0, irq}, 1);

        // R7: write 0 no effect, write 1 clears
        wr(8'h08, 32'd0);
        rd(8'h08, v, v1); chk("R7 write zero keeps", v, 1);
        wr(8'h08, 32'd1);
        rd(8'h08, v, v1); chk("R7 w1c", v, 0);
        @(negedge clk);
        chk("R8 irq follows clear", {31'd0, irq}, 0);

        // R7: set wins over clear in same cycle
        wr(8'h10, 32'd9);
        @(negedge clk);
        reg_addr = 8'h08; reg_wdata = 32'd1; reg_we = 1'b1; tick_bus = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; tick_bus = 1'b0;
        rd(8'h08, v, v1); chk("R7 set wins", v, 1);
        rd(8'h24, v, v1); chk("R7 count at match", v, 9);

        // R10: counter write ignored, unmapped read zero
        wr(8'h24, 32'h55);
        rd(8'h24, v, v1); chk("R10 cnt write ignored", v, 9);
        rd(8'h30, v, v1); chk("R10 unmapped", v, 0);

        // R5: restart mode
        do_reset();
        wr(8'h10, 32'd3);
        wr(8'h00, 32'h041);
        ticks(1'b1, 1'b0, 3);
        rd(8'h24, v, v1); chk("R5 at compare", v, 3);
        ticks(1'b1, 1'b0, 1);
        rd(8'h24, v, v1); chk("R5 restart to zero", v, 0);
        rd(8'h08, v, v1); chk("R5 flag set", v, 1);
        ticks(1'b1, 1'b0, 2);
        rd(8'h24, v, v1); chk("R5 counts again", v, 2);

        // R1: enable clear holds
        wr(8'h00, 32'h040);
        ticks(1'b1, 1'b1, 5);
        rd(8'h24, v, v1); chk("R1 hold when disabled", v, 2);

        // R3: prescaler write resets phase
        do_reset();
        wr(8'h04, 32'd3);
        wr(8'h00, 32'h241);
        ticks(1'b1, 1'b0, 2);
        wr(8'h04, 32'd3);
        ticks(1'b1, 1'b0, 3);
        rd(8'h24, v, v1); chk("R3 phase reset", v, 0);
        ticks(1'b1, 1'b0, 1);
        rd(8'h24, v, v1); chk("R3 step after reset phase", v, 1);

        // R6 R4: passed compare and wrap on 8-bit instance
        do_reset();
        wr(8'h00, 32'h241);
        ticks(1'b1, 1'b0, 5);
        wr(8'h10, 32'd2);
        ticks(1'b1, 1'b0, 10);
        rd(8'h08, v, v1); chk("R6 passed compare silent", v1, 0);
        rd(8'h24, v, v1); chk("R6 narrow count", v1, 15);
        ticks(1'b1, 1'b0, 242);
        rd(8'h24, v, v1); chk("R4 wrapped count", v1, 1);
        rd(8'h08, v, v1); chk("R6 before wrap match", v1, 0);
        ticks(1'b1, 1'b0, 1);
        rd(8'h08, v, v1); chk("R6 match after wrap", v1, 1);
        wr(8'h08, 32'd1);
        ticks(1'b1, 1'b0, 248);
        rd(8'h24, v, v1); chk("R4 narrow at 250", v1, 250);
        wr(8'h10, 32'd4);
        ticks(1'b1, 1'b0, 9);
        rd(8'h08, v, v1); chk("R6 delta across zero early", v1, 0);
        ticks(1'b1, 1'b0, 1);
        rd(8'h08, v, v1); chk("R6 delta across zero match", v1, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule